// File: doc/BRIEF.md
# Legacy Memory Attribute Router

This block decides where each access into the legacy address window is sent. The window runs from 768 KB (0xC0000) up to 1 MB (0xFFFFF). The block keeps seven byte-wide attribute registers behind a simple configuration port. Software writes and reads these registers at offsets 0x90 through 0x96. Each register carries read-enable and write-enable bits for one or two address segments.

For every request, the block takes an address, a read/write flag and an initiator type, and answers at once. It either claims the access and routes it to main memory, or passes it to the downstream I/O hub, which terminates it. The attribute bits only govern accesses that the processor initiates. Graphics-port, PCI and hub initiators that hit the window always go to main memory. Addresses outside the window raise an out-of-window flag, and neither routing output is asserted for them.

The routing decision is purely combinational from the request pins and the stored attributes. The request side is a plain decode with no valid/ready pair: no state is held per request, so there is nothing to stall, and no back-pressure applies. A configuration write is accepted on the clock edge where `cfg_wr_en` is high. Routing sees the new value from the following cycle.

Top module: `legacy_attr_router`

## Requirements
- R1: After reset, every attribute register reads back 0x00, and every processor access inside the window is routed to the hub.
- R2: In each register nibble, bit 0 is read enable and bit 1 is write enable. Nibble bits 3:2 are reserved: they ignore writes and read as 0. The lower nibble of offset 0x90 is entirely unused and reads as 0. Read-back therefore masks offset 0x90 with 0x30 and offsets 0x91 to 0x96 with 0x33.
- R3: A configuration write to any offset outside 0x90 to 0x96 changes no register and no routing. A read from such an offset returns 0x00.
- R4: A configuration write affects routing and read-back starting in the cycle after the clock edge that accepts it, and not before.
- R5: Segment map:
  - The upper nibble of 0x90 governs the 64 KB segment from 0xF0000 to 0xFFFFF.
  - Offsets 0x91 to 0x96 govern the range from 0xC0000 to 0xEFFFF in 16 KB regions, in ascending order. The lower nibble of each register covers the lower-addressed region.
- R6: With RE=0 and WE=0, processor reads and writes go to the hub.
- R7: With RE=1 and WE=0, processor reads go to memory and processor writes go to the hub.
- R8: With RE=0 and WE=1, processor writes go to memory and processor reads go to the hub.
- R9: With RE=1 and WE=1, processor reads and writes both go to memory.
- R10: Initiator encodings are 0 = processor, 1 = graphics port, 2 = PCI and 3 = hub. An in-window access with any initiator other than 0 goes to memory regardless of the attributes.
- R11: An address below 0xC0000 or at or above 0x100000 raises `out_of_window`, and both routing outputs stay low.
- R12: For an in-window address, exactly one of `route_mem` and `route_hub` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset (for both write and read) |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read-back of the register at `cfg_addr` |
| req_addr | input | 32 | Access byte address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_initiator | input | 2 | Initiator: 0 processor, 1 graphics, 2 PCI, 3 hub |
| route_mem | output | 1 | Access is claimed and sent to main memory |
| route_hub | output | 1 | Access is passed to the downstream hub |
| out_of_window | output | 1 | Address lies outside 0xC0000 to 0xFFFFF |

## Verification
The main table programs a mix of read-only, write-only, read/write and disabled segments. It then issues processor reads and writes at the first and last byte of each kind of segment, which separates the four attribute codes and catches any swap of the RE and WE bits. The same segments are then hit by non-processor initiators, which tells whether the processor-only qualification is applied. Addresses just below and just above the window test the window bounds.

A directed sweep enables one region at a time and probes that region and its neighbours, which exposes an off-by-one or swapped-nibble segment map. Further directed cases cover:
- reserved-bit masking;
- writes to stray offsets;
- the one-cycle latency of a configuration write.

// File: rtl/lar_pkg.sv
package lar_pkg;

  typedef enum logic [1:0] {
    INIT_CPU = 2'd0,
    INIT_GFX = 2'd1,
    INIT_PCI = 2'd2,
    INIT_HUB = 2'd3
  } initiator_e;

  // Per-segment attribute pair as stored
  typedef struct packed {
    logic we;
    logic re;
  } seg_attr_t;

  localparam int unsigned ATTR_W = $bits(seg_attr_t);

  // Register slot that holds a segment: segment 0 is the 64 KB top block
  function automatic int unsigned seg_reg_idx(input int unsigned seg);
    return (seg == 0) ? 0 : 1 + (seg - 1) / 2;
  endfunction

  // Nibble (0 = low, 1 = high) that holds a segment
  function automatic int unsigned seg_nibble(input int unsigned seg);
    return (seg == 0) ? 1 : (seg - 1) % 2;
  endfunction

endpackage

// File: rtl/lar_attr_regs.sv
module lar_attr_regs
  import lar_pkg::*;
#(
  parameter int unsigned NUM_REGION = 12,
  parameter logic [7:0]  CFG_BASE   = 8'h90,
  localparam int unsigned NUM_SEG   = NUM_REGION + 1,
  localparam int unsigned NUM_REG   = 1 + (NUM_REGION + 1) / 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_wr_en,
  input  logic [7:0]                cfg_addr,
  input  logic [7:0]                cfg_wdata,
  output logic [7:0]                cfg_rdata,
  output logic [ATTR_W*NUM_SEG-1:0] attr_flat
);

  logic       off_hit;
  logic [7:0] off_idx;
  logic [7:0] contrib [NUM_SEG];

  assign off_idx = cfg_addr - CFG_BASE;
  assign off_hit = (cfg_addr >= CFG_BASE) && (off_idx < 8'(NUM_REG));

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    localparam int unsigned RIDX = seg_reg_idx(s);
    localparam int unsigned NIB  = seg_nibble(s);
    seg_attr_t attr_q;
    logic      sel;

    assign sel = off_hit && (off_idx == 8'(RIDX));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        attr_q <= '0;
      end else if (cfg_wr_en && sel) begin
        attr_q <= seg_attr_t'(cfg_wdata[NIB*4 +: ATTR_W]);
      end
    end

    assign attr_flat[s*ATTR_W +: ATTR_W] = attr_q;
    assign contrib[s] = sel ? (8'(attr_q) << (NIB*4)) : 8'h00;
  end

  always_comb begin
    cfg_rdata = 8'h00;
    for (int s = 0; s < NUM_SEG; s++) begin
      cfg_rdata = cfg_rdata | contrib[s];
    end
  end

endmodule

// File: rtl/lar_seg_decode.sv
module lar_seg_decode #(
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned NUM_REGION   = 12,
  parameter int unsigned REGION_SHIFT = 14,
  localparam int unsigned NUM_SEG     = NUM_REGION + 1,
  localparam int unsigned SEG_W       = $clog2(NUM_SEG)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_window,
  output logic [SEG_W-1:0]  seg_idx
);

  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(32'h000C_0000);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(32'h0010_0000);
  localparam logic [ADDR_W-1:0] TOP_LO = WIN_LO + ADDR_W'(NUM_REGION << REGION_SHIFT);

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] region;

  assign in_window = (addr >= WIN_LO) && (addr < WIN_HI);
  assign offset    = addr - WIN_LO;
  assign region    = offset >> REGION_SHIFT;

  always_comb begin
    if (addr >= TOP_LO) begin
      seg_idx = '0;
    end else begin
      seg_idx = SEG_W'(region) + SEG_W'(1);
    end
  end

endmodule

// File: rtl/lar_route_policy.sv
module lar_route_policy
  import lar_pkg::*;
(
  input  logic       in_window,
  input  logic       is_write,
  input  logic [1:0] initiator,
  input  seg_attr_t  attr,
  output logic       to_mem,
  output logic       to_hub,
  output logic       oow
);

  logic cpu_access;
  logic enabled;

  assign cpu_access = (initiator_e'(initiator) == INIT_CPU);
  assign enabled    = is_write ? attr.we : attr.re;

  always_comb begin
    oow    = !in_window;
    to_mem = 1'b0;
    to_hub = 1'b0;
    if (in_window) begin
      if (!cpu_access || enabled) begin
        to_mem = 1'b1;
      end else begin
        to_hub = 1'b1;
      end
    end
  end

endmodule

// File: rtl/legacy_attr_router.sv
module legacy_attr_router
  import lar_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned NUM_REGION = 12,
  parameter logic [7:0]  CFG_BASE   = 8'h90,
  localparam int unsigned NUM_SEG   = NUM_REGION + 1,
  localparam int unsigned SEG_W     = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_initiator,
  output logic              route_mem,
  output logic              route_hub,
  output logic              out_of_window
);

  logic [ATTR_W*NUM_SEG-1:0] attr_flat;
  logic                      in_window;
  logic [SEG_W-1:0]          seg_idx;
  seg_attr_t                 seg_attr;

  lar_attr_regs #(
    .NUM_REGION(NUM_REGION),
    .CFG_BASE  (CFG_BASE)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr_en(cfg_wr_en),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .attr_flat(attr_flat)
  );

  lar_seg_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_REGION(NUM_REGION)
  ) u_dec (
    .addr     (req_addr),
    .in_window(in_window),
    .seg_idx  (seg_idx)
  );

  always_comb begin
    seg_attr = '0;
    for (int s = 0; s < NUM_SEG; s++) begin
      if (seg_idx == SEG_W'(s)) begin
        seg_attr = seg_attr_t'(attr_flat[s*ATTR_W +: ATTR_W]);
      end
    end
  end

  lar_route_policy u_pol (
    .in_window(in_window),
    .is_write (req_write),
    .initiator(req_initiator),
    .attr     (seg_attr),
    .to_mem   (route_mem),
    .to_hub   (route_hub),
    .oow      (out_of_window)
  );

endmodule

// File: rtl/lar_router_chk.sv
module lar_router_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter logic [7:0]  CFG_BASE = 8'h90,
  parameter int unsigned NUM_REG  = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [7:0]        cfg_addr,
  input logic [7:0]        cfg_wdata,
  input logic [7:0]        cfg_rdata,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_initiator,
  input logic              route_mem,
  input logic              route_hub,
  input logic              out_of_window
);

  logic       off_in;
  logic [7:0] rd_mask;

  assign off_in  = (cfg_addr >= CFG_BASE) && (cfg_addr < CFG_BASE + 8'(NUM_REG));
  assign rd_mask = (cfg_addr == CFG_BASE) ? 8'h30 : 8'h33;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~rd_mask) == 8'h00) else $error("reserved bits set"); // R2

  AST_STRAY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !off_in |-> cfg_rdata == 8'h00) else $error("stray offset read nonzero"); // R3

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && off_in) |=> ($stable(cfg_addr) -> cfg_rdata == ($past(cfg_wdata) & rd_mask)))
    else $error("write not visible next cycle"); // R4

  AST_NONCPU_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_of_window && req_initiator != 2'd0) |-> route_mem) else $error("non-cpu not to memory"); // R10

  AST_OOW_NO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_window |-> (!route_mem && !route_hub)) else $error("route while out of window"); // R11

  AST_ONE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_of_window |-> $onehot({route_mem, route_hub})) else $error("route not exclusive"); // R12

  AST_WINDOW_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_window == ((req_addr < ADDR_W'(32'h000C_0000)) || (req_addr >= ADDR_W'(32'h0010_0000))))
    else $error("window flag wrong"); // R11

endmodule

bind legacy_attr_router lar_router_chk #(
  .ADDR_W  (ADDR_W),
  .CFG_BASE(CFG_BASE),
  .NUM_REG (1 + (NUM_REGION + 1) / 2)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr_en    (cfg_wr_en),
  .cfg_addr     (cfg_addr),
  .cfg_wdata    (cfg_wdata),
  .cfg_rdata    (cfg_rdata),
  .req_addr     (req_addr),
  .req_initiator(req_initiator),
  .route_mem    (route_mem),
  .route_hub    (route_hub),
  .out_of_window(out_of_window)
);

// File: tb/legacy_attr_router_tb.sv
module legacy_attr_router_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [31:0] req_addr = 32'h0;
  logic        req_write = 1'b0;
  logic [1:0]  req_initiator = 2'd0;
  logic        route_mem, route_hub, out_of_window;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  legacy_attr_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_addr(req_addr),
    .req_write(req_write), .req_initiator(req_initiator), .route_mem(route_mem),
    .route_hub(route_hub), .out_of_window(out_of_window)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic [1:0]  init;
    logic        mem;
    logic        hub;
    logic        oow;
    logic [7:0]  req;
  } vec_t;

  // Config for the table: 0x90=0x10, 0x91=0x21, 0x92=0x03, others 0
  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{32'h000F_8000, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 8'd7},  // R7 top seg read
    '{32'h000F_8000, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 8'd7},  // R7 top seg write
    '{32'h000C_0000, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 8'd7},  // R7
    '{32'h000C_3FFF, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 8'd7},  // R7
    '{32'h000C_4000, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 8'd8},  // R8
    '{32'h000C_7FFF, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 8'd8},  // R8
    '{32'h000C_8000, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 8'd9},  // R9
    '{32'h000C_BFFF, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 8'd9},  // R9
    '{32'h000C_C000, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 8'd6},  // R6
    '{32'h000C_C000, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 8'd6},  // R6
    '{32'h000E_FFFF, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 8'd6},  // R6
    '{32'h000C_C000, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 8'd10}, // R10 PCI
    '{32'h000F_0000, 1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 8'd10}, // R10 graphics
    '{32'h000E_0000, 1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 8'd10}, // R10 hub
    '{32'h000B_FFFF, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 8'd11}, // R11 below
    '{32'h0010_0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 8'd11}  // R11 above
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] off, input logic [7:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = off; cfg_wdata = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] off, output logic [7:0] data);
    @(negedge clk);
    cfg_addr = off;
    #1 data = cfg_rdata;
  endtask

  task automatic probe(input logic [31:0] a, input logic w, input logic [1:0] ini,
                       output logic [2:0] res);
    @(negedge clk);
    req_addr = a; req_write = w; req_initiator = ini;
    #1 res = {route_mem, route_hub, out_of_window};
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [2:0] res;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 7; i++) begin
      cfg_read(8'h90 + 8'(i), rd);
      check($sformatf("R1 reset readback 0x%0h", 8'h90 + i), 32'(rd), 32'h0);
    end
    probe(32'h000C_0000, 1'b0, 2'd0, res);
    check("R1 reset cpu read to hub", 32'(res), 32'b010);
    probe(32'h000F_FFFF, 1'b1, 2'd0, res);
    check("R1 reset cpu write to hub", 32'(res), 32'b010);

    // Table
    cfg_write(8'h90, 8'h10);
    cfg_write(8'h91, 8'h21);
    cfg_write(8'h92, 8'h03);
    for (int v = 0; v < NV; v++) begin
      probe(VEC[v].addr, VEC[v].wr, VEC[v].init, res);
      check($sformatf("R%0d vec %0d", VEC[v].req, v), 32'(res),
            32'({VEC[v].mem, VEC[v].hub, VEC[v].oow}));
    end

    // R2: reserved bits masked
    cfg_write(8'h93, 8'hFF);
    cfg_read(8'h93, rd);
    check("R2 mask 0x93", 32'(rd), 32'h33);
    cfg_write(8'h90, 8'hFF);
    cfg_read(8'h90, rd);
    check("R2 mask 0x90", 32'(rd), 32'h30);
    cfg_write(8'h90, 8'h00);
    cfg_write(8'h93, 8'h00);

    // R3: stray offsets
    cfg_write(8'h97, 8'hFF);
    cfg_write(8'h8F, 8'hFF);
    cfg_read(8'h97, rd);
    check("R3 read 0x97", 32'(rd), 32'h0);
    cfg_read(8'h8F, rd);
    check("R3 read 0x8F", 32'(rd), 32'h0);
    cfg_read(8'h91, rd);
    check("R3 0x91 untouched", 32'(rd), 32'h21);
    probe(32'h000D_0000, 1'b0, 2'd0, res);
    check("R3 routing untouched", 32'(res), 32'b010);

    // R4: write latency
    @(negedge clk);
    req_addr = 32'h000E_8000; req_write = 1'b0; req_initiator = 2'd0;
    cfg_wr_en = 1'b1; cfg_addr = 8'h96; cfg_wdata = 8'h01;
    #1 check("R4 before accept", 32'({route_mem, route_hub}), 32'b01);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    #1 check("R4 after accept", 32'({route_mem, route_hub}), 32'b10);
    cfg_write(8'h96, 8'h00);
    cfg_write(8'h91, 8'h00);
    cfg_write(8'h92, 8'h00);

    // R5: one region at a time
    for (int r = 0; r < 12; r++) begin
      logic [31:0] base;
      base = 32'h000C_0000 + 32'(r) * 32'h4000;
      cfg_write(8'h91 + 8'(r / 2), (r % 2 == 0) ? 8'h01 : 8'h10);
      probe(base, 1'b0, 2'd0, res);
      check($sformatf("R5 region %0d start", r), 32'(res), 32'b100);
      probe(base + 32'h3FFF, 1'b0, 2'd0, res);
      check($sformatf("R5 region %0d end", r), 32'(res), 32'b100);
      if (r > 0) begin
        probe(base - 32'h1, 1'b0, 2'd0, res);
        check($sformatf("R5 below region %0d", r), 32'(res), 32'b010);
      end
      probe(base + 32'h4000, 1'b0, 2'd0, res);
      check($sformatf("R5 above region %0d", r), 32'(res), 32'b010);
      cfg_write(8'h91 + 8'(r / 2), 8'h00);
    end
    cfg_write(8'h90, 8'h20);
    probe(32'h000F_0000, 1'b1, 2'd0, res);
    check("R5 top seg write", 32'(res), 32'b100);
    probe(32'h000E_FFFF, 1'b1, 2'd0, res);
    check("R5 below top seg", 32'(res), 32'b010);
    // R12 spot check on a write-only top segment
    probe(32'h000F_FFFF, 1'b0, 2'd0, res);
    check("R12 read of write-only top", 32'(res), 32'b010);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule